// File: doc/BRIEF.md
# Thread Context Table and Round-Robin Issue Scheduler

This block sits at the front of a fine-grained multithreaded RISC core. It keeps a small table of thread contexts. Each slot holds a program counter, an instruction word that was fetched ahead of time, a global thread number and a state. In every cycle it selects one runnable slot and hands that slot's instruction, number and PC to the decode stage. Slots are visited in rotating order, so a thread with a long memory wait never blocks the others.

When an instruction leaves the pipeline, its write-back/predecode return gives the thread's next PC and the newly fetched instruction. The table records both and sets the thread's next state:
- If the thread halted, its slot becomes free.
- If the next PC is not inside the local address slice [base, limit), the thread is marked for migration. It is then offered to the inter-core network as its global number and PC.
- If the instruction fetch missed in the cache, the thread waits until a miss-return supplies the instruction.
- Otherwise the thread is runnable again.

Threads that arrive from other cores take the lowest free slot.

Top module: `thread_ctx_sched`

## Requirements
- R1: After reset every slot is free. `iss_valid_o` and `mo_valid_o` are 0 and `mi_ready_o` is 1.
- R2: An accepted incoming thread (`mi_valid_i` and `mi_ready_o`) is written into the lowest-indexed free slot as runnable, with its global number, PC and instruction. `mi_ready_o` is 0 exactly when no slot is free.
- R3: At most one slot is issued per cycle. The issued slot's index, global number, PC and instruction appear on the `iss_*` outputs in that cycle. The slot is then in flight and is not issued again until its write-back returns.
- R4: The issued slot is the first runnable slot after the previously issued slot, in increasing index order with wrap-around. The search starts at slot 0 after reset. When no slot is runnable, `iss_valid_o` is 0 and the rotation point holds.
- R5: A write-back to an in-flight slot stores `wb_pc_i` and `wb_instr_i`. With no halt, no miss and a local PC, the slot becomes runnable again.
- R6: A write-back with `wb_miss_i`, a local PC and no halt parks the slot, so it is not issued. A later miss-return naming that slot stores `mr_instr_i` and makes the slot runnable. A miss-return naming a slot that is not parked changes nothing.
- R7: A write-back with a non-local PC and no halt marks the slot for migration; this takes precedence over a miss. The lowest-indexed slot marked for migration is offered on `mo_valid_o`, `mo_gid_o` and `mo_pc_o`. The slot becomes free in the cycle after `mo_ready_i` accepts it.
- R8: A write-back with `wb_halt_i` frees the slot, whatever the PC or the miss flag.
- R9: A write-back naming a slot that is not in flight changes nothing.
- R10: A PC is local when base <= PC < limit. A PC equal to base, or equal to limit-1, is local. A PC equal to limit is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_i | input | AW | Lowest local address |
| limit_i | input | AW | First address above the local slice |
| iss_valid_o | output | 1 | An instruction is issued this cycle |
| iss_slot_o | output | SW | Table slot of the issued thread |
| iss_gid_o | output | GW | Global number of the issued thread |
| iss_pc_o | output | AW | PC of the issued instruction |
| iss_instr_o | output | IW | Issued instruction word |
| wb_valid_i | input | 1 | Write-back/predecode return is valid |
| wb_slot_i | input | SW | Slot the return belongs to |
| wb_pc_i | input | AW | Thread's next PC |
| wb_instr_i | input | IW | Instruction fetched at the next PC |
| wb_miss_i | input | 1 | The fetch missed in the instruction cache |
| wb_halt_i | input | 1 | The predecoded instruction ends the thread |
| mr_valid_i | input | 1 | Miss-return is valid |
| mr_slot_i | input | SW | Slot whose fetch completed |
| mr_instr_i | input | IW | Instruction delivered by the miss-return |
| mo_valid_o | output | 1 | A thread is offered for migration |
| mo_ready_i | input | 1 | Network accepts the offered thread |
| mo_gid_o | output | GW | Global number of the offered thread |
| mo_pc_o | output | AW | PC of the offered thread |
| mi_valid_i | input | 1 | An incoming thread is offered |
| mi_ready_o | output | 1 | A free slot can take the incoming thread |
| mi_gid_i | input | GW | Global number of the incoming thread |
| mi_pc_i | input | AW | PC of the incoming thread |
| mi_instr_i | input | IW | Instruction at that PC |

## Verification
The write-back return and the issue selection often fall in the same cycle. One slot can come back while the scheduler is choosing among the others. The returned slot must only become eligible in the following cycle, and the rotation must then continue from the slot that was just issued. A random bench keeps several threads in flight and sends returns, miss-returns and incoming or outgoing migrations in the same cycle as issues. A model of the slot states, written from the requirements, predicts each cycle's issued slot, its contents and the handshake outputs. Each prediction is compared at the ports.

// File: rtl/tct_pkg.sv
// Shared types for the thread context table.
// Assumes: nothing beyond IEEE 1800-2017.
package tct_pkg;

    // Slot life cycle; each value is held by at most one path of the table.
    typedef enum logic [2:0] {
        ST_FREE  = 3'd0,
        ST_READY = 3'd1,
        ST_BUSY  = 3'd2,
        ST_WAIT  = 3'd3,
        ST_MIGR  = 3'd4
    } tstate_e;

    localparam int ST_W = 3;

endpackage

// File: rtl/tct_rr_pick.sv
// Rotating picker: returns the first set request after index `last`,
// wrapping around. Assumes N >= 2.
module tct_rr_pick #(
    parameter int N  = 4,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Search N positions starting just after the last grant.
    always_comb begin
        found = 1'b0;
        idx   = last;
        for (int k = 1; k <= N; k++) begin
            int j;
            j = (int'(last) + k) % N;
            if (!found && req[j]) begin
                found = 1'b1;
                idx   = IW'(j);
            end
        end
    end
endmodule

// File: rtl/tct_low_pick.sv
// Fixed-priority picker: returns the lowest set request index.
// Assumes N >= 2.
module tct_low_pick #(
    parameter int N  = 4,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest index wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int j = N - 1; j >= 0; j--) begin
            if (req[j]) begin
                found = 1'b1;
                idx   = IW'(j);
            end
        end
    end
endmodule

// File: rtl/tct_range_chk.sv
// Tells whether an address lies in the half-open slice [base, limit).
// Assumes unsigned addresses; an empty slice makes every address remote.
module tct_range_chk #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] limit,
    output logic          is_local
);
    // Two unsigned compares.
    always_comb is_local = (addr >= base) && (addr < limit);
endmodule

// File: rtl/thread_ctx_sched.sv
// Thread context table with round-robin issue.
// Holds NTHR slots (PC, prefetched instruction, global id, state). Issues one
// runnable slot per cycle in rotating order, takes write-back/predecode
// returns, miss-returns, and incoming and outgoing migrations.
// Assumes: NTHR >= 2; the decode stage always accepts an issued instruction;
// a write-back names the slot that was issued.
module thread_ctx_sched #(
    parameter int NTHR = 4,
    parameter int AW   = 32,
    parameter int IW   = 32,
    parameter int GW   = 8,
    localparam int SW  = $clog2(NTHR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] limit_i,
    output logic          iss_valid_o,
    output logic [SW-1:0] iss_slot_o,
    output logic [GW-1:0] iss_gid_o,
    output logic [AW-1:0] iss_pc_o,
    output logic [IW-1:0] iss_instr_o,
    input  logic          wb_valid_i,
    input  logic [SW-1:0] wb_slot_i,
    input  logic [AW-1:0] wb_pc_i,
    input  logic [IW-1:0] wb_instr_i,
    input  logic          wb_miss_i,
    input  logic          wb_halt_i,
    input  logic          mr_valid_i,
    input  logic [SW-1:0] mr_slot_i,
    input  logic [IW-1:0] mr_instr_i,
    output logic          mo_valid_o,
    input  logic          mo_ready_i,
    output logic [GW-1:0] mo_gid_o,
    output logic [AW-1:0] mo_pc_o,
    input  logic          mi_valid_i,
    output logic          mi_ready_o,
    input  logic [GW-1:0] mi_gid_i,
    input  logic [AW-1:0] mi_pc_i,
    input  logic [IW-1:0] mi_instr_i
);
    import tct_pkg::*;

    tstate_e        st_q    [NTHR];
    logic [AW-1:0]  pc_q    [NTHR];
    logic [IW-1:0]  instr_q [NTHR];
    logic [GW-1:0]  gid_q   [NTHR];
    logic [SW-1:0]  rr_q;

    logic [NTHR-1:0]      ready_v, free_v, migr_v;
    logic [NTHR*ST_W-1:0] st_flat;
    logic                 free_any, migr_any, wb_local;
    logic [SW-1:0]        free_idx, migr_idx;
    tstate_e              wb_next;

    // Per-slot state flags for the pickers and the checker.
    for (genvar g = 0; g < NTHR; g++) begin : g_flags
        assign ready_v[g] = (st_q[g] == ST_READY);
        assign free_v[g]  = (st_q[g] == ST_FREE);
        assign migr_v[g]  = (st_q[g] == ST_MIGR);
        assign st_flat[g*ST_W +: ST_W] = st_q[g];
    end

    tct_rr_pick #(.N(NTHR), .IW(SW)) u_issue_pick (
        .req(ready_v), .last(rr_q), .found(iss_valid_o), .idx(iss_slot_o)
    );
    tct_low_pick #(.N(NTHR), .IW(SW)) u_free_pick (
        .req(free_v), .found(free_any), .idx(free_idx)
    );
    tct_low_pick #(.N(NTHR), .IW(SW)) u_migr_pick (
        .req(migr_v), .found(migr_any), .idx(migr_idx)
    );
    tct_range_chk #(.AW(AW)) u_range (
        .addr(wb_pc_i), .base(base_i), .limit(limit_i), .is_local(wb_local)
    );

    // Issue and migration outputs read straight from the table.
    assign iss_gid_o   = gid_q[iss_slot_o];
    assign iss_pc_o    = pc_q[iss_slot_o];
    assign iss_instr_o = instr_q[iss_slot_o];
    assign mo_valid_o  = migr_any;
    assign mo_gid_o    = gid_q[migr_idx];
    assign mo_pc_o     = pc_q[migr_idx];
    assign mi_ready_o  = free_any;

    // State after write-back: halt, then remote PC, then miss, then runnable.
    always_comb begin
        if (wb_halt_i)      wb_next = ST_FREE;
        else if (!wb_local) wb_next = ST_MIGR;
        else if (wb_miss_i) wb_next = ST_WAIT;
        else                wb_next = ST_READY;
    end

    // Rotation point: the last issued slot; reset so slot 0 is searched first.
    always_ff @(posedge clk) begin
        if (!rst_n)           rr_q <= SW'(NTHR - 1);
        else if (iss_valid_o) rr_q <= iss_slot_o;
    end

    // One update process per slot; the hit conditions need distinct states.
    for (genvar g = 0; g < NTHR; g++) begin : g_slot
        logic iss_hit, wb_hit, mr_hit, mo_hit, mi_hit;
        assign iss_hit = iss_valid_o && (iss_slot_o == SW'(g));
        assign wb_hit  = wb_valid_i && (wb_slot_i == SW'(g)) && (st_q[g] == ST_BUSY);
        assign mr_hit  = mr_valid_i && (mr_slot_i == SW'(g)) && (st_q[g] == ST_WAIT);
        assign mo_hit  = migr_any && mo_ready_i && (migr_idx == SW'(g));
        assign mi_hit  = mi_valid_i && free_any && (free_idx == SW'(g));

        // Apply whichever event owns this slot in this cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[g]    <= ST_FREE;
                pc_q[g]    <= '0;
                instr_q[g] <= '0;
                gid_q[g]   <= '0;
            end else if (iss_hit) begin
                st_q[g] <= ST_BUSY;
            end else if (wb_hit) begin
                st_q[g]    <= wb_next;
                pc_q[g]    <= wb_pc_i;
                instr_q[g] <= wb_instr_i;
            end else if (mr_hit) begin
                st_q[g]    <= ST_READY;
                instr_q[g] <= mr_instr_i;
            end else if (mo_hit) begin
                st_q[g] <= ST_FREE;
            end else if (mi_hit) begin
                st_q[g]    <= ST_READY;
                pc_q[g]    <= mi_pc_i;
                instr_q[g] <= mi_instr_i;
                gid_q[g]   <= mi_gid_i;
            end
        end
    end
endmodule

// File: rtl/tct_checker.sv
// Temporal checks on the thread context table, bound to its top module.
// Assumes the slot states are seen through the packed vector st_flat.
module tct_checker #(
    parameter int NTHR = 4,
    parameter int AW   = 32,
    parameter int SW   = $clog2(NTHR)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [AW-1:0]       base_i,
    input logic [AW-1:0]       limit_i,
    input logic                iss_valid_o,
    input logic [SW-1:0]       iss_slot_o,
    input logic                wb_valid_i,
    input logic [SW-1:0]       wb_slot_i,
    input logic [AW-1:0]       wb_pc_i,
    input logic                wb_miss_i,
    input logic                wb_halt_i,
    input logic                mo_valid_o,
    input logic                mo_ready_i,
    input logic                mi_valid_i,
    input logic                mi_ready_o,
    input logic [NTHR*3-1:0]   st_flat
);
    logic wb_busy;
    assign wb_busy = wb_valid_i && (st_flat[wb_slot_i*3 +: 3] == 3'd2);

    p_no_reissue_r3: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid_o |=> !(iss_valid_o && iss_slot_o == $past(iss_slot_o)));

    p_wb_runnable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_busy && !wb_halt_i && !wb_miss_i && wb_pc_i >= base_i && wb_pc_i < limit_i)
        |=> iss_valid_o);

    p_offer_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mo_valid_o && !mo_ready_i) |=> mo_valid_o);

    p_halt_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_busy && wb_halt_i) |=> mi_ready_o);

    p_arrival_runnable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mi_valid_i && mi_ready_o) |=> iss_valid_o);
endmodule

bind thread_ctx_sched tct_checker #(.NTHR(NTHR), .AW(AW), .SW(SW)) u_tct_checker (
    .clk(clk), .rst_n(rst_n), .base_i(base_i), .limit_i(limit_i),
    .iss_valid_o(iss_valid_o), .iss_slot_o(iss_slot_o),
    .wb_valid_i(wb_valid_i), .wb_slot_i(wb_slot_i), .wb_pc_i(wb_pc_i),
    .wb_miss_i(wb_miss_i), .wb_halt_i(wb_halt_i),
    .mo_valid_o(mo_valid_o), .mo_ready_i(mo_ready_i),
    .mi_valid_i(mi_valid_i), .mi_ready_o(mi_ready_o), .st_flat(st_flat)
);

// File: tb/thread_ctx_sched_tb_top.sv
`timescale 1ns/1ps
// Random plus directed bench; a state model built from the requirements
// predicts every cycle's outputs.
module thread_ctx_sched_tb_top;
    localparam int NTHR = 4;
    localparam int AW   = 32;
    localparam int IW   = 32;
    localparam int GW   = 8;
    localparam int SW   = $clog2(NTHR);
    localparam int NCYC = 4000;
    // Model states: 0 free, 1 runnable, 2 in flight, 3 parked on miss, 4 migrating.
    localparam int M_FREE = 0, M_RDY = 1, M_BUSY = 2, M_WAIT = 3, M_MIGR = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] base_i = 32'h1000, limit_i = 32'h2000;
    logic iss_valid_o; logic [SW-1:0] iss_slot_o; logic [GW-1:0] iss_gid_o;
    logic [AW-1:0] iss_pc_o; logic [IW-1:0] iss_instr_o;
    logic wb_valid_i = 0; logic [SW-1:0] wb_slot_i = 0; logic [AW-1:0] wb_pc_i = 0;
    logic [IW-1:0] wb_instr_i = 0; logic wb_miss_i = 0, wb_halt_i = 0;
    logic mr_valid_i = 0; logic [SW-1:0] mr_slot_i = 0; logic [IW-1:0] mr_instr_i = 0;
    logic mo_valid_o; logic mo_ready_i = 0; logic [GW-1:0] mo_gid_o; logic [AW-1:0] mo_pc_o;
    logic mi_valid_i = 0; logic mi_ready_o; logic [GW-1:0] mi_gid_i = 0;
    logic [AW-1:0] mi_pc_i = 0; logic [IW-1:0] mi_instr_i = 0;

    int n_tests = 0, n_fail = 0;
    int m_st [NTHR];
    logic [AW-1:0] m_pc [NTHR];
    logic [IW-1:0] m_ins [NTHR];
    logic [GW-1:0] m_gid [NTHR];
    int m_rr;

    always #4 clk = ~clk;   // 125 MHz

    thread_ctx_sched #(.NTHR(NTHR), .AW(AW), .IW(IW), .GW(GW)) dut_i (.*);

    // Count one check; print a FAIL line on mismatch.
    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // First model slot in a given state, lowest index first; -1 if none.
    function automatic int low_of(input int s);
        for (int j = 0; j < NTHR; j++) if (m_st[j] == s) return j;
        return -1;
    endfunction

    // Next runnable slot after the rotation point (R4).
    function automatic int rr_next();
        for (int k = 1; k <= NTHR; k++) begin
            int j = (m_rr + k) % NTHR;
            if (m_st[j] == M_RDY) return j;
        end
        return -1;
    endfunction

    // PC choice mixing the slice edges (R10) with interior and remote values.
    function automatic logic [AW-1:0] pick_pc();
        int r = $urandom % 10;
        if (r == 0) return base_i;
        if (r == 1) return limit_i;
        if (r == 2) return limit_i - 1;
        if (r == 3) return 32'h3000 + ($urandom % 32'h100);
        return base_i + ($urandom % (limit_i - base_i));
    endfunction

    // Compare all outputs against the model state.
    task automatic compare();
        int e_iss = rr_next();
        int e_mo = low_of(M_MIGR);
        check(iss_valid_o == (e_iss >= 0), "R3/R4 iss_valid", 64'(iss_valid_o), 64'(e_iss >= 0));
        if (e_iss >= 0) begin
            check(iss_slot_o == SW'(e_iss), "R4 rotation slot", 64'(iss_slot_o), 64'(e_iss));
            check({iss_gid_o, iss_pc_o, iss_instr_o} == {m_gid[e_iss], m_pc[e_iss], m_ins[e_iss]},
                  "R3/R5/R6 issued contents", {iss_pc_o, iss_instr_o}, {m_pc[e_iss], m_ins[e_iss]});
        end
        check(mi_ready_o == (low_of(M_FREE) >= 0), "R2/R8 mi_ready", 64'(mi_ready_o), 64'(low_of(M_FREE) >= 0));
        check(mo_valid_o == (e_mo >= 0), "R7/R10 mo_valid", 64'(mo_valid_o), 64'(e_mo >= 0));
        if (e_mo >= 0)
            check({mo_gid_o, mo_pc_o} == {m_gid[e_mo], m_pc[e_mo]}, "R7 offered thread",
                  {mo_gid_o, mo_pc_o}, {m_gid[e_mo], m_pc[e_mo]});
    endtask

    // Advance the model by one clock edge with the inputs just driven.
    task automatic step_model();
        int e_iss = rr_next();
        int e_free = low_of(M_FREE);
        int e_mo = low_of(M_MIGR);
        int ws = int'(wb_slot_i), ms = int'(mr_slot_i);
        bit wb_hit = wb_valid_i && m_st[ws] == M_BUSY;   // R9: other states ignore it
        bit mr_hit = mr_valid_i && m_st[ms] == M_WAIT;   // R6: ignored unless parked
        bit loc = (wb_pc_i >= base_i) && (wb_pc_i < limit_i);
        if (e_iss >= 0) begin m_st[e_iss] = M_BUSY; m_rr = e_iss; end
        if (wb_hit) begin
            m_pc[ws] = wb_pc_i; m_ins[ws] = wb_instr_i;
            m_st[ws] = wb_halt_i ? M_FREE : !loc ? M_MIGR : wb_miss_i ? M_WAIT : M_RDY;
        end
        if (mr_hit) begin m_st[ms] = M_RDY; m_ins[ms] = mr_instr_i; end
        if (e_mo >= 0 && mo_ready_i) m_st[e_mo] = M_FREE;
        if (e_free >= 0 && mi_valid_i) begin
            m_st[e_free] = M_RDY; m_pc[e_free] = mi_pc_i;
            m_ins[e_free] = mi_instr_i; m_gid[e_free] = mi_gid_i;
        end
    endtask

    // Random input choice; phase 0 only fills the table (R2 back-pressure).
    task automatic drive(input bit fill_only);
        int b = low_of(M_BUSY);
        mi_valid_i = fill_only || ($urandom % 4 == 0);
        mi_gid_i = GW'($urandom); mi_pc_i = base_i + ($urandom % 32'h800); mi_instr_i = $urandom;
        mo_ready_i = !fill_only && ($urandom % 2 == 0);
        wb_valid_i = 0; mr_valid_i = 0; wb_miss_i = 0; wb_halt_i = 0;
        if (fill_only) return;
        if ($urandom % 3 != 0) begin
            wb_valid_i = 1;
            wb_slot_i = (b >= 0 && $urandom % 5 != 0) ? SW'(b) : SW'($urandom);
            wb_pc_i = pick_pc(); wb_instr_i = $urandom;
            wb_miss_i = ($urandom % 4 == 0); wb_halt_i = ($urandom % 8 == 0);
        end
        if ($urandom % 3 == 0) begin
            int w = low_of(M_WAIT);
            mr_valid_i = 1;
            mr_slot_i = (w >= 0 && $urandom % 4 != 0) ? SW'(w) : SW'($urandom);
            mr_instr_i = $urandom;
        end
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Main sequence: reset, table fill, then random traffic.
    initial begin
        void'($urandom(32'd1234));
        for (int j = 0; j < NTHR; j++) begin
            m_st[j] = M_FREE; m_pc[j] = '0; m_ins[j] = '0; m_gid[j] = '0;
        end
        m_rr = NTHR - 1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: idle outputs straight after reset.
        check(!iss_valid_o && !mo_valid_o && mi_ready_o, "R1 reset state",
              {iss_valid_o, mo_valid_o, mi_ready_o}, 3'b001);
        for (int c = 0; c < NCYC; c++) begin
            if (c > 0) @(negedge clk);
            compare();
            drive(c < NTHR + 4);
            step_model();
        end
        @(negedge clk);
        compare();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule